// File: doc/BRIEF.md
# Gauge Low-Power Mode Sequencer

This block decides when a battery gauge may drop out of its active state and how it gets back. Three things drive it: the level of the single-wire host line, an indication of whether charge is flowing, and a command for shipping the product. If the host line stays low long enough and no charge is flowing, the gauge goes to sleep. While asleep it wakes at long, fixed intervals so that temperature can be updated. On every third of these wakes it stays up for a longer window and measures activity before it sleeps again. For shipping, the gauge can be sent into a deeper state through a two-write command handshake. Once that command is armed, noise on the host line does not keep the gauge awake.

All timing runs off a one-pulse-per-second `tick_1hz` input. The three durations are parameters: the line-low qualification (`LOW_S`, 16 s), the sleep interval (`WAKE_S`, 4 h) and the activity-check window (`CHECK_S`, 15 min). The activity test depends on the magnitude filter threshold. If the threshold is non-zero, the test reads the `above_thr` comparator. If the threshold is zero, the test counts converter pulses instead. The command handshake also fires the other maintenance commands as one-cycle one-hot strobes for the neighbouring logic.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state is active (`pwr_state_o` = 0; encoding 0 active, 1 sleep, 2 ship, 3 wake-up). The same reset also clears the stored command bits, the ship-armed flag, the wake count and all command strobes.
- R2: In the active state with no ship command armed, the sequencer enters sleep in the cycle after the `LOW_S`-th consecutive tick during which the line was low, provided the activity test reports quiet at that point.
- R3: Any cycle in which the line is high returns the line-low qualification count to zero. After that, a full `LOW_S` low ticks are needed again.
- R4: If the threshold is non-zero and `above_thr` is 1, the sequencer stays active even after the qualification is met. It enters sleep one cycle after `above_thr` falls.
- R5: If `filt_zero` is 1, `above_thr` is ignored. The activity test is then quiet only while fewer than 2 `conv_pulse` events have been seen since the line was last high or since the last wake-up.
- R6: In sleep, the `WAKE_S`-th tick moves the sequencer to the wake-up state. It pulses `wake_pulse_o` for one cycle and increments `wake_cnt_o`, which was cleared on entry to sleep from the active or ship state.
- R7: Wake-ups number 1, 4, 7 and so on, counted since sleep was entered from the active or ship state, are check wakes. A check wake stays in the wake-up state for `CHECK_S` ticks and then sleeps if the activity test is quiet, or goes active if it is not. Every other wake sleeps again after `LOW_S` low ticks.
- R8: A high line level in the sleep, wake-up or ship state makes the state active in the next cycle.
- R9: A write to address 1 stores data bits 5, 4, 3, 1 and 0 as command bits; bits 7, 6 and 2 are not stored. A later write of 0xA9 to address 0 strobes `cmd_fire_o` for exactly the highest stored bit, in the priority order 5, 4, 3, 1, 0, and clears all stored command bits.
- R10: A write to address 0 of any value other than 0xA9 causes no strobe and leaves the stored command bits unchanged.
- R11: A strobe of bit 0 arms ship mode. Once armed, every tick counts toward qualification whatever the line level, and the ship state is entered one cycle after the `LOW_S`-th such tick.
- R12: Leaving the ship state clears the armed flag. If the line then stays low, the sequencer goes to sleep and not back to ship.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| line_hi | input | 1 | Host serial line level |
| above_thr | input | 1 | Activity above the non-zero filter threshold |
| filt_zero | input | 1 | Filter threshold is zero |
| conv_pulse | input | 1 | One converter count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| mode_cmd_o | output | 8 | Stored command bits at their bit positions |
| cmd_fire_o | output | 8 | One-hot command execution strobe |
| pwr_state_o | output | 2 | Power state |
| ship_armed_o | output | 1 | Ship command armed |
| wake_pulse_o | output | 1 | Temperature-update wake strobe |
| wake_cnt_o | output | WCNT_W | Wakes since sleep entry |

## Verification
The command strobe and the cleared command bits appear one clock after the control write. The armed flag appears one clock after that. State changes that a tick causes directly, such as wake-ups, the end of a check window or ship entry, become visible one clock after the tick. Sleep entry after qualification also takes one further clock. The bench therefore drives each tick or write on a falling edge and leaves two rising edges before it samples on a falling edge. Strobes that last only one cycle are caught by a monitor that runs on every falling edge.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_SHIP   = 2'd2,
    PM_WAKE   = 2'd3
  } pm_state_e;

  localparam logic [7:0] CMD_MASK = 8'h3B;
  localparam logic [7:0] GO_CODE  = 8'hA9;
endpackage

// File: rtl/pms_cmd.sv
module pms_cmd #(
  parameter int ADDR_W    = 7,
  parameter int MODE_ADDR = 1,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        mode_q,
  output logic [7:0]        fire_q
);
  import pms_pkg::*;

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic       mode_wr, go_wr;
  logic [7:0] pick;
  logic [7:0] mode_n, fire_n;

  assign mode_wr = wr && (addr == MODE_A);
  assign go_wr   = wr && (addr == CTRL_A) && (wdata == GO_CODE);

  always_comb begin
    pick = '0;
    for (int b = 7; b >= 0; b--) begin
      if (mode_q[b] && (pick == '0)) pick[b] = 1'b1;
    end
  end

  always_comb begin
    mode_n = mode_q;
    fire_n = '0;
    if (mode_wr) begin
      mode_n = wdata & CMD_MASK;
    end else if (go_wr) begin
      mode_n = '0;
      fire_n = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      fire_q <= '0;
    end else begin
      mode_q <= mode_n;
      fire_q <= fire_n;
    end
  end

  // R9
  fire_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_q));

  // R10
  bad_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTRL_A && wdata != GO_CODE) |=> (fire_q == '0 && mode_q == $past(mode_q)));

  // R9
  go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> (mode_q == '0));
endmodule

// File: rtl/pms_act.sv
module pms_act (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic conv_pulse,
  input  logic filt_zero,
  input  logic above_thr,
  output logic quiet
);
  logic [1:0] cnt_q;
  logic [1:0] cnt_n;
  logic       cnt_en;

  assign cnt_en = clr || (conv_pulse && cnt_q != 2'd2);

  always_comb begin
    if (clr) cnt_n = 2'd0;
    else     cnt_n = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= 2'd0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign quiet = filt_zero ? (cnt_q < 2'd2) : !above_thr;

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 2'd2);
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm #(
  parameter int LOW_S   = 16,
  parameter int WAKE_S  = 14400,
  parameter int CHECK_S = 900,
  parameter int WCNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_hi,
  input  logic              quiet,
  input  logic              arm,
  output pms_pkg::pm_state_e st_q,
  output logic              armed_q,
  output logic              wpulse_q,
  output logic [WCNT_W-1:0] wcnt_q
);
  import pms_pkg::*;

  localparam int SEC_MAX = (WAKE_S > CHECK_S) ? WAKE_S : CHECK_S;
  localparam int SEC_W   = $clog2(SEC_MAX + 1);
  localparam int QUAL_W  = $clog2(LOW_S + 1);
  localparam logic [SEC_W-1:0]  WAKE_LAST  = SEC_W'(WAKE_S - 1);
  localparam logic [SEC_W-1:0]  CHECK_LAST = SEC_W'(CHECK_S - 1);
  localparam logic [QUAL_W-1:0] QUAL_FULL  = QUAL_W'(LOW_S);

  pm_state_e         st_n;
  logic [SEC_W-1:0]  sec_q, sec_n;
  logic [QUAL_W-1:0] qual_q, qual_n;
  logic [1:0]        phase_q, phase_n;
  logic              chk_q, chk_n;
  logic              armed_n, wpulse_n;
  logic [WCNT_W-1:0] wcnt_n;
  logic              qual_tick;

  assign qual_tick = tick && (qual_q != QUAL_FULL);

  always_comb begin
    st_n     = st_q;
    sec_n    = sec_q;
    qual_n   = qual_q;
    phase_n  = phase_q;
    chk_n    = chk_q;
    armed_n  = armed_q;
    wcnt_n   = wcnt_q;
    wpulse_n = 1'b0;
    unique case (st_q)
      PM_ACTIVE: begin
        if (armed_q) begin
          if (qual_tick) qual_n = qual_q + 1'b1;
          if (qual_q == QUAL_FULL) begin
            st_n    = PM_SHIP;
            armed_n = 1'b0;
            qual_n  = '0;
          end
        end else begin
          if (line_hi)        qual_n = '0;
          else if (qual_tick) qual_n = qual_q + 1'b1;
          if (!line_hi && qual_q == QUAL_FULL && quiet) begin
            st_n    = PM_SLEEP;
            sec_n   = '0;
            phase_n = 2'd0;
            wcnt_n  = '0;
            qual_n  = '0;
          end
        end
      end
      PM_SLEEP: begin
        if (line_hi) begin
          st_n   = PM_ACTIVE;
          qual_n = '0;
        end else if (tick) begin
          if (sec_q == WAKE_LAST) begin
            st_n     = PM_WAKE;
            sec_n    = '0;
            qual_n   = '0;
            chk_n    = (phase_q == 2'd0);
            phase_n  = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
            wcnt_n   = wcnt_q + 1'b1;
            wpulse_n = 1'b1;
          end else begin
            sec_n = sec_q + 1'b1;
          end
        end
      end
      PM_WAKE: begin
        if (line_hi) begin
          st_n   = PM_ACTIVE;
          qual_n = '0;
        end else if (chk_q) begin
          if (tick) begin
            if (sec_q == CHECK_LAST) begin
              st_n   = quiet ? PM_SLEEP : PM_ACTIVE;
              sec_n  = '0;
              qual_n = '0;
            end else begin
              sec_n = sec_q + 1'b1;
            end
          end
        end else begin
          if (qual_tick) qual_n = qual_q + 1'b1;
          if (qual_q == QUAL_FULL) begin
            st_n   = PM_SLEEP;
            sec_n  = '0;
            qual_n = '0;
          end
        end
      end
      PM_SHIP: begin
        if (line_hi) begin
          st_n   = PM_ACTIVE;
          qual_n = '0;
        end
      end
      default: st_n = PM_ACTIVE;
    endcase
    if (arm) begin
      armed_n = 1'b1;
      qual_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PM_ACTIVE;
      sec_q    <= '0;
      qual_q   <= '0;
      phase_q  <= 2'd0;
      chk_q    <= 1'b0;
      armed_q  <= 1'b0;
      wcnt_q   <= '0;
      wpulse_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      sec_q    <= sec_n;
      qual_q   <= qual_n;
      phase_q  <= phase_n;
      chk_q    <= chk_n;
      armed_q  <= armed_n;
      wcnt_q   <= wcnt_n;
      wpulse_q <= wpulse_n;
    end
  end

  // R8
  line_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PM_ACTIVE && line_hi) |=> (st_q == PM_ACTIVE));

  // R2
  sleep_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SLEEP && $past(st_q) == PM_ACTIVE) |-> ($past(qual_q) == QUAL_FULL && !$past(line_hi)));

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wpulse_q |-> (st_q == PM_WAKE && $past(st_q) == PM_SLEEP));

  // R11
  ship_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SHIP && $past(st_q) != PM_SHIP) |-> $past(armed_q));

  // R12
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_ACTIVE && $past(st_q) == PM_SHIP && !$past(arm)) |-> !armed_q);

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int LOW_S   = 16,
  parameter int WAKE_S  = 14400,
  parameter int CHECK_S = 900,
  parameter int WCNT_W  = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              line_hi,
  input  logic              above_thr,
  input  logic              filt_zero,
  input  logic              conv_pulse,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        mode_cmd_o,
  output logic [7:0]        cmd_fire_o,
  output logic [1:0]        pwr_state_o,
  output logic              ship_armed_o,
  output logic              wake_pulse_o,
  output logic [WCNT_W-1:0] wake_cnt_o
);
  import pms_pkg::*;

  logic      rst_s1, rst_i;
  logic      quiet, arm, act_clr;
  pm_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  pms_cmd #(.ADDR_W(ADDR_W), .MODE_ADDR(1), .CTRL_ADDR(0)) u_cmd (
    .clk(clk), .rst_n(rst_i), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mode_q(mode_cmd_o), .fire_q(cmd_fire_o)
  );

  assign arm     = cmd_fire_o[0];
  assign act_clr = line_hi || wake_pulse_o;

  pms_act u_act (
    .clk(clk), .rst_n(rst_i), .clr(act_clr), .conv_pulse(conv_pulse),
    .filt_zero(filt_zero), .above_thr(above_thr), .quiet(quiet)
  );

  pms_fsm #(.LOW_S(LOW_S), .WAKE_S(WAKE_S), .CHECK_S(CHECK_S), .WCNT_W(WCNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_i), .tick(tick_1hz), .line_hi(line_hi), .quiet(quiet),
    .arm(arm), .st_q(st), .armed_q(ship_armed_o), .wpulse_q(wake_pulse_o),
    .wcnt_q(wake_cnt_o)
  );

  assign pwr_state_o = st;
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int LOW_S = 16, WAKE_S = 20, CHECK_S = 30;
  localparam int ST_ACT = 0, ST_SLP = 1, ST_SHP = 2, ST_WAK = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1hz = 0, line_hi = 0, above_thr = 0, filt_zero = 0, conv_pulse = 0;
  logic reg_wr = 0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] mode_cmd_o, cmd_fire_o;
  logic [1:0] pwr_state_o;
  logic ship_armed_o, wake_pulse_o;
  logic [7:0] wake_cnt_o;

  int checks = 0, errors = 0, fire_n = 0, wake_n = 0;
  logic [7:0] last_fire = '0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.LOW_S(LOW_S), .WAKE_S(WAKE_S), .CHECK_S(CHECK_S)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .line_hi(line_hi),
    .above_thr(above_thr), .filt_zero(filt_zero), .conv_pulse(conv_pulse),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mode_cmd_o(mode_cmd_o), .cmd_fire_o(cmd_fire_o), .pwr_state_o(pwr_state_o),
    .ship_armed_o(ship_armed_o), .wake_pulse_o(wake_pulse_o), .wake_cnt_o(wake_cnt_o)
  );

  always @(negedge clk) begin
    if (cmd_fire_o != 0) begin last_fire = cmd_fire_o; fire_n++; end
    if (wake_pulse_o) wake_n++;
  end

  function automatic int exp_state(int qual);
    return (qual >= LOW_S) ? ST_SLP : ST_ACT;
  endfunction

  function automatic logic [7:0] exp_fire(logic [7:0] m);
    logic [7:0] s = m & 8'h3B;
    for (int b = 7; b >= 0; b--) if (s[b]) return 8'(1 << b);
    return 8'h00;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1hz = 1;
      @(negedge clk) tick_1hz = 0;
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk) begin reg_wr = 1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 0;
    @(negedge clk);
  endtask

  task automatic blip();
    @(negedge clk) line_hi = 1;
    @(negedge clk) line_hi = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int q, f0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 state", pwr_state_o, ST_ACT);
    check("R1 mode", mode_cmd_o, 0);
    check("R1 armed", ship_armed_o, 0);
    check("R1 wakes", wake_cnt_o, 0);
    check("R1 fire", cmd_fire_o, 0);

    // R2 / R3: qualification with an interruption
    blip();
    tk(10); blip(); tk(15);
    check("R3 restart", pwr_state_o, ST_ACT);
    tk(1);
    check("R2 sleep", pwr_state_o, ST_SLP);
    blip();
    check("R8 sleep exit", pwr_state_o, ST_ACT);

    // R4: activity holds active
    above_thr = 1;
    tk(LOW_S);
    check("R4 held", pwr_state_o, ST_ACT);
    @(negedge clk) above_thr = 0;
    @(negedge clk); @(negedge clk);
    check("R4 release", pwr_state_o, ST_SLP);
    blip();

    // R5: zero threshold uses converter counts
    filt_zero = 1; above_thr = 1;
    @(negedge clk) conv_pulse = 1;
    @(negedge clk) conv_pulse = 0;
    tk(LOW_S);
    check("R5 one count", pwr_state_o, ST_SLP);
    blip();
    repeat (2) begin
      @(negedge clk) conv_pulse = 1;
      @(negedge clk) conv_pulse = 0;
    end
    tk(LOW_S + 2);
    check("R5 two counts", pwr_state_o, ST_ACT);
    blip(); filt_zero = 0; above_thr = 0;

    // R2/R3/R8 random line patterns against a model
    q = 0;
    for (int i = 0; i < 300; i++) begin
      line_hi = (($urandom % 4) == 0);
      tk(1);
      if (line_hi) q = 0; else if (q < LOW_S) q++;
      check("R3 random", pwr_state_o, exp_state(q));
      if (q >= LOW_S) begin
        line_hi = 1; @(negedge clk); @(negedge clk);
        check("R8 random exit", pwr_state_o, ST_ACT);
        q = 0;
      end
    end
    line_hi = 0; blip();

    // R6 / R7: wake schedule
    tk(LOW_S);
    check("R2 enter", pwr_state_o, ST_SLP);
    f0 = wake_n;
    tk(WAKE_S - 1);
    check("R6 before wake", pwr_state_o, ST_SLP);
    tk(1);
    check("R6 wake1", pwr_state_o, ST_WAK);
    check("R6 cnt1", wake_cnt_o, 1);
    check("R6 pulse", wake_n - f0, 1);
    tk(CHECK_S - 1);
    check("R7 check hold", pwr_state_o, ST_WAK);
    tk(1);
    check("R7 check quiet", pwr_state_o, ST_SLP);
    tk(WAKE_S);
    check("R6 cnt2", wake_cnt_o, 2);
    tk(LOW_S - 1);
    check("R7 plain hold", pwr_state_o, ST_WAK);
    tk(1);
    check("R7 plain sleep", pwr_state_o, ST_SLP);
    tk(WAKE_S); tk(LOW_S);
    check("R7 wake3 sleep", pwr_state_o, ST_SLP);
    tk(WAKE_S);
    check("R6 cnt4", wake_cnt_o, 4);
    above_thr = 1;
    tk(LOW_S);
    check("R7 wake4 is check", pwr_state_o, ST_WAK);
    tk(CHECK_S - LOW_S);
    check("R7 check busy", pwr_state_o, ST_ACT);
    check("R6 pulses total", wake_n - f0, 4);
    above_thr = 0; blip();

    // R9 / R10: command handshake
    f0 = fire_n;
    wr(7'd1, 8'hFF);
    check("R9 stored", mode_cmd_o, 8'h3B);
    wr(7'd0, 8'hA9);
    check("R9 prio5", last_fire, exp_fire(8'hFF));
    check("R9 cleared", mode_cmd_o, 0);
    wr(7'd1, 8'h0A); wr(7'd0, 8'hA9);
    check("R9 prio3", last_fire, exp_fire(8'h0A));
    wr(7'd1, 8'h12); wr(7'd0, 8'h55);
    check("R10 kept", mode_cmd_o, 8'h12);
    check("R10 nofire", fire_n - f0, 2);
    wr(7'd0, 8'hA9);
    check("R9 prio4", last_fire, exp_fire(8'h12));
    wr(7'd1, 8'hC4);
    check("R9 unstored", mode_cmd_o, 0);
    wr(7'd0, 8'hA9);
    check("R9 empty", fire_n - f0, 3);
    check("R9 armed not", ship_armed_o, 0);

    // R11 / R12: ship
    wr(7'd1, 8'h03); wr(7'd0, 8'hA9);
    check("R9 prio1", last_fire, 8'h02);
    wr(7'd1, 8'h01); wr(7'd0, 8'hA9);
    check("R11 fire", last_fire, 8'h01);
    check("R11 armed", ship_armed_o, 1);
    for (int i = 0; i < LOW_S - 1; i++) begin blip(); tk(1); end
    check("R11 not yet", pwr_state_o, ST_ACT);
    blip(); tk(1);
    check("R11 ship", pwr_state_o, ST_SHP);
    blip();
    check("R12 glitch", pwr_state_o, ST_ACT);
    check("R12 disarmed", ship_armed_o, 0);
    tk(LOW_S);
    check("R12 sleeps", pwr_state_o, ST_SLP);

    summary();
    $finish;
  end
endmodule